// File: doc/BRIEF.md
# Sequential stream prefetch buffer

This block sits between an instruction cache and the memory below it. Every miss the cache reports is answered with the requested block, and the block at the next sequential address is fetched as well. The extra block is not written into the cache. It is parked in a holding slot next to the cache, so a block that turns out to be useless cannot evict a line the cache still needs.

When the cache misses again, the slot is looked up before memory is asked. A hit on the slot returns the parked block in the cycle after the miss is accepted, empties the slot and starts fetching the block after it. If the block the cache wants is still on its way from memory as a prefetch, the miss waits for that response instead of asking for the block a second time. A miss on an unrelated address discards the parked block and any prefetch in flight, fetches the demand block first and then starts a new prefetch.

The cache raises one miss at a time with a valid/ready handshake and receives the block as a one-cycle fill pulse. Memory takes requests through a valid/ready handshake and returns responses in order, one per accepted request, with at most one request outstanding at any time.

Top module: `spb_prefetch`

## Requirements
- R1: While reset is held and in the first cycle after it, miss_ready is 1, fill_valid is 0 and mem_req_valid is 0.
- R2: A miss on an address that is neither parked nor being prefetched produces exactly one memory request carrying that address. fill_valid is high for one cycle, in the cycle after the memory response, and fill_data equals the response data.
- R3: After every fill for address A, the next memory request accepted is for A+1 modulo 2^AW. The data of that prefetch never appears on fill_valid unless a later miss asks for that address.
- R4: A miss on the parked address raises fill_valid in the cycle after the miss is accepted, with the parked data. No memory request for that address is made.
- R5: A parked block is served once: a hit empties the slot, so a second miss on the same address goes to memory.
- R6: A hit on the slot at address A starts a prefetch of A+1 without any further miss.
- R7: A miss on the address of a prefetch that is still in flight makes no second memory request. It is filled from that prefetch's response.
- R8: A miss on any other address discards the parked block and any prefetch in flight. A later miss on either discarded address goes to memory.
- R9: No memory request is presented between an accepted request and its response. A pending prefetch is sent before a demand request that is waiting behind it.
- R10: miss_ready stays low from the cycle after a miss is accepted through the fill cycle. Each accepted miss gets exactly one fill.
- R11: A memory request that is not accepted stays valid with the same address until it is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| miss_valid | input | 1 | Cache presents a miss |
| miss_addr | input | AW | Block address of the miss |
| miss_ready | output | 1 | Block can accept a miss this cycle |
| fill_valid | output | 1 | One-cycle pulse returning the missed block |
| fill_data | output | DW | Block returned to the cache |
| mem_req_valid | output | 1 | Read request to memory |
| mem_req_addr | output | AW | Block address of the memory request |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_rsp_valid | input | 1 | Memory returns a block, in request order |
| mem_rsp_data | input | DW | Block returned by memory |

## Verification
The bench goes after a miss that lands on a prefetch still in flight. A design that compared only against the slot would ask memory for the same block twice, and one that compared against the address without knowing whether the data had arrived would fill with stale data. It repeats a miss right after a slot hit, where a slot that is not emptied would serve the block a second time. It also switches to an unrelated address while a prefetch is outstanding; a design that kept that prefetch would park it and later serve a block the stream had abandoned. Address wrap at the top of the space and random memory back-pressure are mixed in, to catch a prefetch address that does not roll over and a request that changes while it waits.

// File: rtl/spb_pkg.sv
// Shared types for the sequential stream prefetch buffer.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package spb_pkg;

    // Demand-side sequencing of one cache miss
    typedef enum logic [1:0] {
        DM_IDLE   = 2'd0,   // waiting for a miss
        DM_REQ    = 2'd1,   // demand request waiting for the memory channel
        DM_RSP    = 2'd2,   // demand request accepted, waiting for its data
        DM_WAITPF = 2'd3    // miss matched a prefetch in flight, waiting for it
    } dm_state_e;

endpackage

// File: rtl/spb_park_slot.sv
// Holding slot for one prefetched block: tag, valid bit and data.
// Provides a combinational lookup against the address of the current miss.
// Assumes: the controller never writes and clears the slot in the same cycle.
module spb_park_slot #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_tag,
    input  logic [DW-1:0] wr_data,
    input  logic          clr,
    input  logic [AW-1:0] lk_addr,
    output logic          lk_hit,
    output logic [DW-1:0] lk_data
);

    logic          vld_q;
    logic [AW-1:0] tag_q;
    logic [DW-1:0] data_q;

    // Valid bit: emptied on any accepted miss, set when a prefetch is parked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
        end else if (clr) begin
            vld_q <= 1'b0;
        end else if (wr_en) begin
            vld_q <= 1'b1;
        end
    end

    // Tag and data capture for a parked prefetch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q  <= '0;
            data_q <= '0;
        end else if (wr_en) begin
            tag_q  <= wr_tag;
            data_q <= wr_data;
        end
    end

    // Lookup against the miss address
    always_comb begin
        lk_hit  = vld_q && (tag_q == lk_addr);
        lk_data = data_q;
    end

    // R8: parking and emptying never collide
    a_r8_no_write_clear_clash: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && clr));

    // R5: a clear leaves nothing to hit on the following cycle
    a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !lk_hit);

endmodule

// File: rtl/spb_pf_tracker.sv
// Tracks the single sequential prefetch: its address, whether it is pending,
// whether its request has been accepted by memory, and whether it was abandoned.
// Assumes: a launch only happens when no prefetch is pending or one completes now.
module spb_pf_tracker #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic [AW-1:0] launch_addr,
    input  logic          fire,
    input  logic          done,
    input  logic          drop,
    output logic          pend,
    output logic          issued,
    output logic          dropped,
    output logic [AW-1:0] addr
);

    // Prefetch life cycle: launch, request accepted, response (or abandoned)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= 1'b0;
            issued  <= 1'b0;
            dropped <= 1'b0;
            addr    <= '0;
        end else begin
            if (done) begin
                pend    <= 1'b0;
                issued  <= 1'b0;
                dropped <= 1'b0;
            end
            if (fire) begin
                issued <= 1'b1;
            end
            if (drop) begin
                dropped <= 1'b1;
            end
            if (launch) begin
                pend    <= 1'b1;
                issued  <= 1'b0;
                dropped <= 1'b0;
                addr    <= launch_addr;
            end
        end
    end

    // R9: the prefetch request is sent only once, and only while pending
    a_r9_fire_once: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (pend && !issued));

    // R6: a new prefetch never overwrites one still in progress
    a_r6_launch_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> (!pend || done));

    // R9: a prefetch completes only after its request went out
    a_r9_done_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pend && issued));

endmodule

// File: rtl/spb_req_arbiter.sv
// Selects which of the prefetch and the demand path drives the memory request.
// The prefetch wins so a stale prefetch drains before the demand request.
// Assumes: the controller never lets both ask in the same cycle.
module spb_req_arbiter #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pf_want,
    input  logic [AW-1:0] pf_addr,
    input  logic          dm_want,
    input  logic [AW-1:0] dm_addr,
    input  logic          mem_req_ready,
    output logic          mem_req_valid,
    output logic [AW-1:0] mem_req_addr,
    output logic          pf_fire,
    output logic          dm_fire
);

    // Request mux with prefetch priority and per-source handshake
    always_comb begin
        mem_req_valid = pf_want || dm_want;
        mem_req_addr  = pf_want ? pf_addr : dm_addr;
        pf_fire       = pf_want && mem_req_ready;
        dm_fire       = !pf_want && dm_want && mem_req_ready;
    end

    // R9: the prefetch and the demand path never ask at once
    a_r9_single_requester: assert property (@(posedge clk) disable iff (!rst_n)
        !(pf_want && dm_want));

endmodule

// File: rtl/spb_ctrl.sv
// Miss controller: looks up the holding slot and the prefetch in flight,
// sequences the demand fetch, returns the fill and starts the next prefetch.
// Assumes: memory answers in order, once per accepted request, and only while
// a request is outstanding.
module spb_ctrl
    import spb_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          miss_valid,
    input  logic [AW-1:0] miss_addr,
    output logic          miss_ready,
    output logic          fill_valid,
    output logic [DW-1:0] fill_data,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_data,
    input  logic          slot_hit,
    input  logic [DW-1:0] slot_data,
    output logic          slot_wr,
    output logic          slot_clr,
    input  logic          pf_pend,
    input  logic          pf_dropped,
    input  logic [AW-1:0] pf_addr,
    output logic          pf_launch,
    output logic [AW-1:0] pf_launch_addr,
    output logic          pf_done,
    output logic          pf_drop,
    input  logic          dm_fire,
    output logic          dm_want,
    output logic [AW-1:0] dm_addr
);

    localparam logic [AW-1:0] NEXT_STEP = AW'(1);

    dm_state_e     state_q;
    logic          fill_q;
    logic [DW-1:0] fdata_q;
    logic [AW-1:0] dm_addr_q;

    logic accept;
    logic rsp_dm;
    logic rsp_pf;
    logic pf_live;
    logic pf_same;
    logic case_hit;
    logic case_arrive;
    logic case_wait;
    logic case_miss;
    logic waitpf_done;

    // Classify the current miss and the current memory response
    always_comb begin
        miss_ready  = (state_q == DM_IDLE) && !fill_q;
        accept      = miss_valid && miss_ready;
        rsp_dm      = mem_rsp_valid && (state_q == DM_RSP);
        rsp_pf      = mem_rsp_valid && (state_q != DM_RSP);
        pf_live     = pf_pend && !pf_dropped;
        pf_same     = pf_live && (pf_addr == miss_addr);
        case_hit    = accept && slot_hit;
        case_arrive = accept && !slot_hit && pf_same && rsp_pf;
        case_wait   = accept && !slot_hit && pf_same && !rsp_pf;
        case_miss   = accept && !slot_hit && !pf_same;
        waitpf_done = (state_q == DM_WAITPF) && rsp_pf;
    end

    // Slot, prefetch and demand-request controls derived from the classification
    always_comb begin
        slot_wr        = rsp_pf && pf_live && (state_q != DM_WAITPF) && !accept;
        slot_clr       = accept;
        pf_done        = rsp_pf;
        pf_drop        = case_miss && pf_pend && !rsp_pf;
        pf_launch      = case_hit || case_arrive || rsp_dm || waitpf_done;
        pf_launch_addr = (case_hit || case_arrive) ? (miss_addr + NEXT_STEP)
                                                   : (dm_addr_q + NEXT_STEP);
        dm_want        = (state_q == DM_REQ) && !pf_pend;
        dm_addr        = dm_addr_q;
        fill_valid     = fill_q;
        fill_data      = fdata_q;
    end

    // Demand sequencing and registered fill pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= DM_IDLE;
            fill_q    <= 1'b0;
            fdata_q   <= '0;
            dm_addr_q <= '0;
        end else begin
            fill_q <= 1'b0;
            case (state_q)
                DM_IDLE: begin
                    if (accept) begin
                        dm_addr_q <= miss_addr;
                        if (case_hit) begin
                            fill_q  <= 1'b1;
                            fdata_q <= slot_data;
                        end else if (case_arrive) begin
                            fill_q  <= 1'b1;
                            fdata_q <= mem_rsp_data;
                        end else if (case_wait) begin
                            state_q <= DM_WAITPF;
                        end else begin
                            state_q <= DM_REQ;
                        end
                    end
                end
                DM_REQ: begin
                    if (dm_fire) begin
                        state_q <= DM_RSP;
                    end
                end
                DM_RSP: begin
                    if (rsp_dm) begin
                        fill_q  <= 1'b1;
                        fdata_q <= mem_rsp_data;
                        state_q <= DM_IDLE;
                    end
                end
                DM_WAITPF: begin
                    if (rsp_pf) begin
                        fill_q  <= 1'b1;
                        fdata_q <= mem_rsp_data;
                        state_q <= DM_IDLE;
                    end
                end
                default: state_q <= DM_IDLE;
            endcase
        end
    end

    // R4: a slot hit fills on the next cycle with the parked data
    a_r4_hit_fills_next: assert property (@(posedge clk) disable iff (!rst_n)
        case_hit |=> (fill_valid && (fill_data == $past(slot_data))));

    // R10: no second miss is taken while one is being served
    a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !miss_ready);

    // R10: the fill is a single-cycle pulse
    a_r10_fill_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> !fill_valid);

    // R3: a prefetch response that nobody waits for is parked, not filled
    a_r3_parked_not_filled: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_pf && (state_q == DM_IDLE) && !accept) |=> !fill_valid);

    // R7: waiting on a prefetch never issues a demand request
    a_r7_wait_no_demand: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DM_WAITPF) |-> !dm_want);

endmodule

// File: rtl/spb_prefetch.sv
// Sequential stream prefetch buffer, top level.
// On each cache miss returns the demand block and prefetches the next block
// into a holding slot outside the cache; later misses check the slot and the
// prefetch in flight before asking memory.
// Assumes: in-order memory, one response per accepted request.
module spb_prefetch #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          miss_valid,
    input  logic [AW-1:0] miss_addr,
    output logic          miss_ready,
    output logic          fill_valid,
    output logic [DW-1:0] fill_data,
    output logic          mem_req_valid,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_req_ready,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_data
);

    logic          slot_hit;
    logic [DW-1:0] slot_data;
    logic          slot_wr;
    logic          slot_clr;
    logic          pf_pend;
    logic          pf_issued;
    logic          pf_dropped;
    logic [AW-1:0] pf_addr;
    logic          pf_launch;
    logic [AW-1:0] pf_launch_addr;
    logic          pf_done;
    logic          pf_drop;
    logic          pf_fire;
    logic          dm_fire;
    logic          dm_want;
    logic [AW-1:0] dm_addr;
    logic          pf_want;
    logic          outst_q;

    assign pf_want = pf_pend && !pf_issued;

    spb_park_slot #(.AW(AW), .DW(DW)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (slot_wr),
        .wr_tag  (pf_addr),
        .wr_data (mem_rsp_data),
        .clr     (slot_clr),
        .lk_addr (miss_addr),
        .lk_hit  (slot_hit),
        .lk_data (slot_data)
    );

    spb_pf_tracker #(.AW(AW)) u_pf (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (pf_launch),
        .launch_addr (pf_launch_addr),
        .fire        (pf_fire),
        .done        (pf_done),
        .drop        (pf_drop),
        .pend        (pf_pend),
        .issued      (pf_issued),
        .dropped     (pf_dropped),
        .addr        (pf_addr)
    );

    spb_req_arbiter #(.AW(AW)) u_arb (
        .clk           (clk),
        .rst_n         (rst_n),
        .pf_want       (pf_want),
        .pf_addr       (pf_addr),
        .dm_want       (dm_want),
        .dm_addr       (dm_addr),
        .mem_req_ready (mem_req_ready),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .pf_fire       (pf_fire),
        .dm_fire       (dm_fire)
    );

    spb_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .miss_valid     (miss_valid),
        .miss_addr      (miss_addr),
        .miss_ready     (miss_ready),
        .fill_valid     (fill_valid),
        .fill_data      (fill_data),
        .mem_rsp_valid  (mem_rsp_valid),
        .mem_rsp_data   (mem_rsp_data),
        .slot_hit       (slot_hit),
        .slot_data      (slot_data),
        .slot_wr        (slot_wr),
        .slot_clr       (slot_clr),
        .pf_pend        (pf_pend),
        .pf_dropped     (pf_dropped),
        .pf_addr        (pf_addr),
        .pf_launch      (pf_launch),
        .pf_launch_addr (pf_launch_addr),
        .pf_done        (pf_done),
        .pf_drop        (pf_drop),
        .dm_fire        (dm_fire),
        .dm_want        (dm_want),
        .dm_addr        (dm_addr)
    );

    // Checker state: a memory request is outstanding until its response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst_q <= 1'b0;
        end else if (mem_req_valid && mem_req_ready) begin
            outst_q <= 1'b1;
        end else if (mem_rsp_valid) begin
            outst_q <= 1'b0;
        end
    end

    // R9: nothing is requested while a request awaits its response
    a_r9_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        outst_q |-> !mem_req_valid);

    // R11: a stalled request holds valid and address
    a_r11_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R1: outputs are quiet in the first cycle out of reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!fill_valid && !mem_req_valid && miss_ready));

endmodule

// File: tb/spb_prefetch_tb.sv
// Bench for spb_prefetch: an in-order memory model with random latency and
// back-pressure, directed corner cases, then random miss streams.
module spb_prefetch_tb_top;

    localparam int AW         = 16;
    localparam int DW         = 32;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 400;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          miss_valid = 1'b0;
    logic [AW-1:0] miss_addr = '0;
    logic          miss_ready;
    logic          fill_valid;
    logic [DW-1:0] fill_data;
    logic          mem_req_valid;
    logic [AW-1:0] mem_req_addr;
    logic          mem_req_ready = 1'b0;
    logic          mem_rsp_valid = 1'b0;
    logic [DW-1:0] mem_rsp_data = '0;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // memory model state
    logic [AW-1:0] req_q[$];
    bit            mem_busy = 1'b0;
    int            mem_cnt = 0;
    logic [AW-1:0] mem_addr = '0;
    int            rsp_count = 0;
    int            logged_now = 0;
    int            lat_min = 0;
    int            lat_max = 2;
    int            ready_pct = 100;
    bit            held = 1'b0;
    logic [AW-1:0] held_addr = '0;

    // reference stream state
    bit            prev_valid = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    int            rsp_snap = 0;
    int            win_lo = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spb_prefetch #(.AW(AW), .DW(DW)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .miss_valid    (miss_valid),
        .miss_addr     (miss_addr),
        .miss_ready    (miss_ready),
        .fill_valid    (fill_valid),
        .fill_data     (fill_data),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data)
    );

    function automatic logic [DW-1:0] data_of(input logic [AW-1:0] a);
        return {a ^ 16'h5A3C, ~a};
    endfunction

    task automatic check(input bit ok, input string msg,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", msg, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // Memory model: in-order, single outstanding, random latency and ready
    always @(negedge clk) begin
        logged_now = 0;
        if (rst_n) begin
            bit was_busy;
            was_busy = mem_busy;
            mem_rsp_valid = 1'b0;
            if (held) begin
                check(mem_req_valid && (mem_req_addr == held_addr),
                      "R11 stalled request held", {16'h0, mem_req_addr}, {16'h0, held_addr});
                held = 1'b0;
            end
            if (mem_busy) begin
                if (mem_cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = data_of(mem_addr);
                    mem_busy      = 1'b0;
                    rsp_count++;
                end else begin
                    mem_cnt--;
                end
            end
            mem_req_ready = ($urandom_range(99) < ready_pct);
            if (mem_req_valid) begin
                if (was_busy) begin
                    check(1'b0, "R9 request while one outstanding", 32'd1, 32'd0);
                end
                if (mem_req_ready) begin
                    req_q.push_back(mem_req_addr);
                    logged_now = 1;
                    mem_busy = 1'b1;
                    mem_addr = mem_req_addr;
                    mem_cnt  = $urandom_range(lat_max, lat_min);
                end else begin
                    held      = 1'b1;
                    held_addr = mem_req_addr;
                end
            end
        end
    end

    // Idle cycles with no miss: no fill may appear
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            step();
            check(!fill_valid, "R3 no fill without a miss", {31'h0, fill_valid}, 32'h0);
        end
    endtask

    // One miss with all expectations derived from the stream reference
    task automatic do_miss(input logic [AW-1:0] b, input string tag);
        int cyc;
        int hi;
        bit fast_exp;
        logic [AW-1:0] nxt;
        while (!miss_ready) step();
        nxt = prev_addr + 16'd1;
        fast_exp = prev_valid && (b == nxt) && (rsp_count > rsp_snap);
        miss_valid = 1'b1;
        miss_addr  = b;
        step();
        miss_valid = 1'b0;
        cyc = 1;
        while (!fill_valid && cyc < 200) begin
            check(!miss_ready, "R10 miss_ready low while busy", {31'h0, miss_ready}, 32'h0);
            step();
            cyc++;
        end
        check(fill_valid, {tag, " fill returned"}, {31'h0, fill_valid}, 32'h1);
        check(fill_data == data_of(b), {tag, " R2 fill data"}, fill_data, data_of(b));
        hi = req_q.size() - logged_now;
        if (!prev_valid) begin
            check(hi - win_lo == 1, "R2 one request on cold miss", hi - win_lo, 1);
            if (hi - win_lo >= 1)
                check(req_q[win_lo] == b, "R2 cold request address",
                      {16'h0, req_q[win_lo]}, {16'h0, b});
        end else begin
            if (hi - win_lo >= 1)
                check(req_q[win_lo] == nxt, "R3 R6 first request after fill is next block",
                      {16'h0, req_q[win_lo]}, {16'h0, nxt});
            else
                check(1'b0, "R3 R6 prefetch request missing", 0, 1);
            if (b == nxt) begin
                check(hi - win_lo == 1, {tag, " R7 no second request for streamed block"},
                      hi - win_lo, 1);
            end else begin
                check(hi - win_lo == 2, {tag, " R8 R9 prefetch then demand"}, hi - win_lo, 2);
                if (hi - win_lo >= 2)
                    check(req_q[win_lo+1] == b, {tag, " R2 demand address"},
                          {16'h0, req_q[win_lo+1]}, {16'h0, b});
            end
        end
        if (fast_exp)
            check(cyc == 1, {tag, " R4 parked block fills next cycle"}, cyc, 1);
        prev_valid = 1'b1;
        prev_addr  = b;
        rsp_snap   = rsp_count;
        win_lo     = hi;
        step();
        check(!fill_valid, "R10 exactly one fill", {31'h0, fill_valid}, 32'h0);
    endtask

    initial begin
        logic [AW-1:0] a;
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        #1;
        check(miss_ready && !fill_valid && !mem_req_valid, "R1 outputs during reset",
              {29'h0, miss_ready, fill_valid, mem_req_valid}, 32'h4);
        rst_n = 1'b1;
        step();
        check(miss_ready && !fill_valid && !mem_req_valid, "R1 outputs after reset",
              {29'h0, miss_ready, fill_valid, mem_req_valid}, 32'h4);

        // directed: cold miss, hit on parked block, repeat after hit
        do_miss(16'h0100, "R2");
        idle(20);
        do_miss(16'h0101, "R4");
        idle(20);
        do_miss(16'h0101, "R5");
        // prefetch still in flight when the miss arrives
        lat_min = 6; lat_max = 6;
        do_miss(16'h0102, "R7");
        lat_min = 0; lat_max = 2;
        idle(20);
        // unrelated miss discards parked block
        do_miss(16'h0800, "R8");
        do_miss(16'h0103, "R8");
        idle(20);
        // wrap at the top of the address space
        do_miss(16'hFFFF, "R3");
        idle(20);
        do_miss(16'h0000, "R3");
        // unrelated miss while a prefetch is in flight
        lat_min = 6; lat_max = 6;
        do_miss(16'h2000, "R8");
        do_miss(16'h3000, "R8");
        lat_min = 0; lat_max = 2;
        idle(20);
        do_miss(16'h2001, "R8");

        // random streams with back-pressure
        ready_pct = 70; lat_min = 0; lat_max = 4;
        for (int n = 0; n < N_RANDOM; n++) begin
            int r;
            r = $urandom_range(99);
            if (r < 50)      a = prev_addr + 16'd1;
            else if (r < 65) a = prev_addr;
            else if (r < 80) a = prev_addr + 16'd2;
            else             a = 16'h4000 + 16'($urandom_range(63));
            idle($urandom_range(5));
            do_miss(a, "R2");
        end
        idle(10);

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule